// File: doc/BRIEF.md
# SRAM Page Guard Register Bank

This block guards a small on-chip SRAM. It holds one write-protect bit per SRAM page. Software can set these bits through a simple register port, but it cannot clear them. Only a reset returns them to zero. On a separate memory write port, the block drops any write that targets a protected page. In the cycle after a dropped write it raises a one-cycle violation pulse.

A second register drives an erase-enable output. That register is guarded by a key state machine. Software must write 0xCA and then 0x53 to the key register before one erase-control write is accepted. Any wrong key returns the machine to its locked state. An erase-control write made while locked is dropped and sets a sticky error flag.

The key machine has three states:
- `KS_LOCKED`: the reset state.
- `KS_ARMED`: the first key has been seen.
- `KS_OPEN`: the guarded write is allowed.

Its transitions are:
- `KS_LOCKED` goes to `KS_ARMED` on a key write of 0xCA. Any other key write keeps it in `KS_LOCKED`.
- `KS_ARMED` goes to `KS_OPEN` on a key write of 0x53. Any other key write, 0xCA included, returns it to `KS_LOCKED`.
- `KS_OPEN` returns to `KS_LOCKED` on any key write. It also returns to `KS_LOCKED` on the erase-control write that it allowed.

Top module: `sram_guard_regs`

## Requirements
- R1: After reset, the protect register, the erase-control register, `page_prot_o` and `erase_en_o` are all zero, and the key machine is locked.
- R2: A register write to byte offset 0x00 ORs write-data bits [31:0] into the protect register. A data bit of 0 never clears a protect bit. Reading offset 0x00 returns the register, which also drives `page_prot_o`.
- R3: Reads of the key register (offset 0x04) return zero. Reads of unmapped offsets, such as 0x0C, also return zero.
- R4: A key write (offset 0x04, data bits [7:0]) of 0xCA followed by a key write of 0x53 opens the lock. The next write to offset 0x08 loads its data bit 0 into `erase_en_o`. Reading offset 0x08 returns {error flag in bit 1, enable in bit 0}.
- R5: A key write that is not the expected next key relocks the machine. So do 0x53 without a preceding 0xCA, a repeated 0xCA, and any key write made while open. After any of these, an erase-control write leaves `erase_en_o` unchanged.
- R6: One accepted erase-control write uses up the unlock. A second erase-control write without a new key pair is ignored.
- R7: An erase-control write made while not open leaves the enable unchanged and sets the error flag (bit 1 of offset 0x08). The flag stays set until reset.
- R8: The page index of a memory write is `mem_addr_i[15:11]`. A memory write to a page whose protect bit is set keeps `mem_we_o` low in the same cycle. It also raises `mem_viol_o` for exactly one cycle, in the cycle after the write.
- R9: A memory write to an unprotected page passes straight to `mem_we_o` and raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_addr_i | input | 16 | Memory write address |
| mem_we_i | input | 1 | Memory write request |
| mem_we_o | output | 1 | Filtered memory write enable |
| mem_viol_o | output | 1 | One-cycle pulse after a dropped write |
| page_prot_o | output | 32 | Per-page protect mask |
| erase_en_o | output | 1 | Erase enable |

## Verification
The hardest behaviour to reach is the set of key orders that look almost right but must still leave the lock closed. These are a wrong value between the two keys, the second key alone, a doubled first key, and an extra key write after the lock has opened. Each order can only be seen through the erase-control register, so the bench ends every order with an erase-control write. It then checks both the unchanged enable and the sticky error bit. A follow-up test writes a second erase-control value after a correct unlock, to show that one unlock allows only one write.

// File: rtl/sram_guard_pkg.sv
package sram_guard_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    localparam int          KEY_W      = 8;
    localparam logic [7:0]  KEY_FIRST  = 8'hCA;
    localparam logic [7:0]  KEY_SECOND = 8'h53;

    localparam int OFS_PROT  = 'h00;
    localparam int OFS_KEY   = 'h04;
    localparam int OFS_ERASE = 'h08;

endpackage

// File: rtl/sg_page_mask.sv
module sg_page_mask #(
    parameter int PAGES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [PAGES-1:0] set_bits,
    output logic [PAGES-1:0] mask
);
    // Set-only bits: a 1 written sets, a 0 written has no effect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else if (set_en)
            mask <= mask | set_bits;
    end
endmodule

// File: rtl/sg_key_gate.sv
module sg_key_gate
    import sram_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             ctl_wr,
    input  logic             ctl_bit,
    output key_state_t       state,
    output logic             erase_en,
    output logic             erase_err
);
    key_state_t state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= KS_LOCKED;
        else
            state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            KS_LOCKED: begin
                if (key_wr && key_val == KEY_FIRST)
                    state_nx = KS_ARMED;
            end
            KS_ARMED: begin
                if (key_wr)
                    state_nx = (key_val == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
            end
            KS_OPEN: begin
                if (key_wr || ctl_wr)
                    state_nx = KS_LOCKED;
            end
            default: state_nx = KS_LOCKED;
        endcase
    end

    // Output register: guarded enable and sticky error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_en  <= 1'b0;
            erase_err <= 1'b0;
        end else if (ctl_wr) begin
            if (state == KS_OPEN)
                erase_en <= ctl_bit;
            else
                erase_err <= 1'b1;
        end
    end
endmodule

// File: rtl/sg_wr_filter.sv
module sg_wr_filter #(
    parameter int PAGES  = 32,
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGES-1:0]  mask,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_we_in,
    output logic              mem_we_out,
    output logic              viol
);
    localparam int PAGE_BITS = $clog2(PAGES);

    logic [PAGE_BITS-1:0] page;
    logic                 hit;
    logic                 unused_low;

    assign page       = mem_addr[MEM_AW-1 -: PAGE_BITS];
    assign unused_low = ^mem_addr[MEM_AW-PAGE_BITS-1:0];
    assign hit        = mask[page];
    assign mem_we_out = mem_we_in & ~hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            viol <= 1'b0;
        else
            viol <= mem_we_in & hit;
    end
endmodule

// File: rtl/sram_guard_regs.sv
module sram_guard_regs
    import sram_guard_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int DATA_W = 32,
    parameter int PAGES  = 32,
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [MEM_AW-1:0] mem_addr_i,
    input  logic              mem_we_i,
    output logic              mem_we_o,
    output logic              mem_viol_o,
    output logic [PAGES-1:0]  page_prot_o,
    output logic              erase_en_o
);
    logic       sel_prot, sel_key, sel_erase;
    logic       prot_wr, key_wr, erase_wr;
    logic       erase_err_q;
    key_state_t key_state;

    assign sel_prot  = (reg_addr == REG_AW'(OFS_PROT));
    assign sel_key   = (reg_addr == REG_AW'(OFS_KEY));
    assign sel_erase = (reg_addr == REG_AW'(OFS_ERASE));

    assign prot_wr  = reg_we & sel_prot;
    assign key_wr   = reg_we & sel_key;
    assign erase_wr = reg_we & sel_erase;

    sg_page_mask #(.PAGES(PAGES)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (prot_wr),
        .set_bits (reg_wdata[PAGES-1:0]),
        .mask     (page_prot_o)
    );

    sg_key_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_val   (reg_wdata[KEY_W-1:0]),
        .ctl_wr    (erase_wr),
        .ctl_bit   (reg_wdata[0]),
        .state     (key_state),
        .erase_en  (erase_en_o),
        .erase_err (erase_err_q)
    );

    sg_wr_filter #(.PAGES(PAGES), .MEM_AW(MEM_AW)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask       (page_prot_o),
        .mem_addr   (mem_addr_i),
        .mem_we_in  (mem_we_i),
        .mem_we_out (mem_we_o),
        .viol       (mem_viol_o)
    );

    // Read mux: key register and unmapped offsets read zero
    always_comb begin
        reg_rdata = '0;
        if (sel_prot)
            reg_rdata = DATA_W'(page_prot_o);
        else if (sel_erase)
            reg_rdata = DATA_W'({erase_err_q, erase_en_o});
    end
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk
    import sram_guard_pkg::*;
#(
    parameter int PAGES  = 32,
    parameter int MEM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MEM_AW-1:0] mem_addr_i,
    input logic              mem_we_i,
    input logic              mem_we_o,
    input logic              mem_viol_o,
    input logic [PAGES-1:0]  page_prot_o,
    input logic              erase_en_o,
    input logic              err,
    input logic              erase_wr,
    input key_state_t        ks
);
    localparam int PAGE_BITS = $clog2(PAGES);

    logic [PAGE_BITS-1:0] pg;
    logic                 prot_hit;
    logic                 unused_chk;

    assign pg         = mem_addr_i[MEM_AW-1 -: PAGE_BITS];
    assign unused_chk = ^mem_addr_i[MEM_AW-PAGE_BITS-1:0];
    assign prot_hit   = page_prot_o[pg];

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((page_prot_o & $past(page_prot_o)) == $past(page_prot_o)));

    a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_i && prot_hit) |-> !mem_we_o);

    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_i && prot_hit) |=> mem_viol_o);

    a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_i && !prot_hit) |-> mem_we_o);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r6_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (ks == KS_OPEN && erase_wr) |=> (ks == KS_LOCKED));

    a_r4_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(erase_en_o) |-> ($past(ks) == KS_OPEN));
endmodule

bind sram_guard_regs sg_guard_chk #(.PAGES(PAGES), .MEM_AW(MEM_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr_i  (mem_addr_i),
    .mem_we_i    (mem_we_i),
    .mem_we_o    (mem_we_o),
    .mem_viol_o  (mem_viol_o),
    .page_prot_o (page_prot_o),
    .erase_en_o  (erase_en_o),
    .err         (erase_err_q),
    .erase_wr    (erase_wr),
    .ks          (key_state)
);

// File: tb/sram_guard_regs_tb.sv
module sram_guard_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [15:0] mem_addr_i = '0;
    logic        mem_we_i = 1'b0;
    logic        mem_we_o;
    logic        mem_viol_o;
    logic [31:0] page_prot_o;
    logic        erase_en_o;

    int checks = 0;
    int errors = 0;

    sram_guard_regs u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_rdata   (reg_rdata),
        .mem_addr_i  (mem_addr_i),
        .mem_we_i    (mem_we_i),
        .mem_we_o    (mem_we_o),
        .mem_viol_o  (mem_viol_o),
        .page_prot_o (page_prot_o),
        .erase_en_o  (erase_en_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic mem_try(input string req, input logic [15:0] a, input logic blocked);
        @(negedge clk);
        mem_addr_i = a; mem_we_i = 1'b1;
        #1 check(req, {31'b0, mem_we_o}, {31'b0, ~blocked});
        @(negedge clk);
        mem_we_i = 1'b0;
        check(req, {31'b0, mem_viol_o}, {31'b0, blocked});
        @(negedge clk);
        check(req, {31'b0, mem_viol_o}, 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_read(8'h00, d); check("R1 prot reg", d, 32'h0);
        reg_read(8'h08, d); check("R1 erase reg", d, 32'h0);
        check("R1 page_prot_o", page_prot_o, 32'h0);
        check("R1 erase_en_o", {31'b0, erase_en_o}, 32'h0);
    endtask

    task automatic t_protect;
        logic [31:0] d;
        reg_write(8'h00, 32'h0000_0011);
        reg_read(8'h00, d); check("R2 set bits", d, 32'h0000_0011);
        reg_write(8'h00, 32'h0);
        reg_read(8'h00, d); check("R2 zero write no clear", d, 32'h0000_0011);
        reg_write(8'h00, 32'h8000_0000);
        reg_read(8'h00, d); check("R2 or in", d, 32'h8000_0011);
        check("R2 page_prot_o", page_prot_o, 32'h8000_0011);
    endtask

    task automatic t_reads;
        logic [31:0] d;
        reg_write(8'h04, 32'h0000_00CA);
        reg_read(8'h04, d); check("R3 key reads zero", d, 32'h0);
        reg_read(8'h0C, d); check("R3 unmapped reads zero", d, 32'h0);
        reg_write(8'h04, 32'h0000_0011);  // relock
    endtask

    task automatic t_wrong_keys;
        logic [31:0] d;
        reg_write(8'h04, 32'hCA); reg_write(8'h04, 32'h12); reg_write(8'h04, 32'h53);
        reg_write(8'h08, 32'h1);
        check("R5 wrong middle key", {31'b0, erase_en_o}, 32'h0);
        reg_read(8'h08, d); check("R7 error flag set", d, 32'h2);
        reg_write(8'h04, 32'h53); reg_write(8'h08, 32'h1);
        check("R5 second key alone", {31'b0, erase_en_o}, 32'h0);
        reg_write(8'h04, 32'hCA); reg_write(8'h04, 32'hCA); reg_write(8'h04, 32'h53);
        reg_write(8'h08, 32'h1);
        check("R5 doubled first key", {31'b0, erase_en_o}, 32'h0);
        reg_read(8'h08, d); check("R7 error flag sticky", d, 32'h2);
    endtask

    task automatic t_unlock;
        logic [31:0] d;
        reg_write(8'h04, 32'hCA); reg_write(8'h04, 32'h53);
        reg_write(8'h08, 32'h1);
        check("R4 enable set", {31'b0, erase_en_o}, 32'h1);
        reg_read(8'h08, d); check("R4 readback", d, 32'h3);
        reg_write(8'h08, 32'h0);
        check("R6 second write ignored", {31'b0, erase_en_o}, 32'h1);
        reg_write(8'h04, 32'hCA); reg_write(8'h04, 32'h53); reg_write(8'h04, 32'h53);
        reg_write(8'h08, 32'h0);
        check("R5 key while open relocks", {31'b0, erase_en_o}, 32'h1);
        reg_write(8'h04, 32'hCA); reg_write(8'h04, 32'h53);
        reg_write(8'h08, 32'h0);
        check("R4 enable cleared", {31'b0, erase_en_o}, 32'h0);
        reg_read(8'h08, d); check("R7 flag held", d, 32'h2);
    endtask

    task automatic t_mem;
        mem_try("R8 page 4 blocked", 16'h2000, 1'b1);
        mem_try("R9 page 5 passes", 16'h2800, 1'b0);
        mem_try("R8 page 31 blocked", 16'hF800, 1'b1);
        mem_try("R8 page 0 top address blocked", 16'h07FF, 1'b1);
        mem_try("R9 page 1 passes", 16'h0800, 1'b0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_protect();
        t_reads();
        t_wrong_keys();
        t_unlock();
        t_mem();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule